// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Readout

This block is a free-running 16-bit up-counter whose count enable comes from one of eight sources. Seven of them are taps of a power-of-two divider on the bus clock (divide by 1 through 64). The eighth is an external clock input. That input is brought into the bus clock domain, and each of its rising edges gives one count.

Software reads the count over an 8-bit bus as two bytes. Reading the upper byte first takes a snapshot of the lower byte. The matching lower-byte read then returns that snapshot, so the two halves always belong to the same 16-bit value even if the counter moves between the two accesses.

A configuration write sets the 3-bit source code and can request a counter restart. The restart request clears the count, restarts the divider and drops any pending snapshot. The block also emits a one-cycle wrap pulse whenever the count rolls over.

Top module: `coherent_timer`

## Requirements
- R1: With source code k in 0..6 and the external code unused, the count advances by exactly one every 2^k bus clocks and never by more than one in a cycle.
- R2: With source code 7, each rising edge of `ext_clk` advances the count by one. The edge is seen through a two-stage synchronizer: a level sampled at clock edge n shows in `count_o` after edge n+2.
- R3: After reset the count is 0, the source code is 0 (divide by 1), no snapshot is pending and `bus_rdata` is 0 while the bus is idle.
- R4: A bus read with `bus_addr` = 0 returns count bits 15:8 and `bus_addr` = 1 returns the low byte. `bus_rdata` is 0 whenever no read is active, and bus writes to either offset leave the count and the snapshot unchanged.
- R5: A read at offset 0 with no snapshot pending stores count bits 7:0 as they stand at that clock edge. The next read at offset 1 returns the stored byte.
- R6: Further offset-0 reads while a snapshot is pending do not replace it. The snapshot stays for any number of idle cycles until an offset-1 read.
- R7: A configuration write with `cfg_clr` = 1 makes `count_o` read 0 after the second clock edge following the write. The request bit then clears itself, so counting resumes.
- R8: The same restart resets the divider. With code k, the first increment after the clear lands 2^k clock edges after the edge that zeroed the count.
- R9: On a tick at 0xFFFF the count becomes 0x0000 and `wrap_o` is high for exactly that one cycle.
- R10: An offset-1 read with no snapshot pending returns the live low byte. A restart or an offset-1 read releases a pending snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 3 | Source code written on `cfg_we` (0..6 divider tap, 7 external) |
| cfg_clr | input | 1 | Restart request written on `cfg_we` |
| ext_clk | input | 1 | External count clock, slower than half the bus clock |
| bus_en | input | 1 | Bus access strobe for the counter bytes |
| bus_wr | input | 1 | Access is a write (ignored by the counter) |
| bus_addr | input | 1 | Byte offset: 0 upper byte, 1 lower byte |
| bus_rdata | output | 8 | Read data, combinational from the current access |
| src_sel | output | 3 | Current source code |
| count_o | output | 16 | Live counter value |
| wrap_o | output | 1 | One-cycle pulse in the cycle the count shows 0 after a rollover |

## Verification
A divider tick is seen in `count_o` one edge after the tap fires. A restart needs two edges: one to capture the request and one to zero the count. An external edge needs three edges to come through the synchronizer. `bus_rdata` is combinational on the current access, while snapshot capture and release take effect at the edge that ends the access. The bench keeps a behavioural model that it steps at every rising edge with the inputs held stable since the previous falling edge. It compares the count, the wrap pulse and the read data a quarter period before the next rising edge, so every delay above is checked in the exact cycle it is due. Directed checks at fixed edge counts back up the restart delay and the snapshot contents.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_CNT_W  = 16;
  localparam int unsigned TMR_BYTE_W = TMR_CNT_W / 2;
  localparam int unsigned TMR_SEL_W  = 3;

  typedef logic [TMR_CNT_W-1:0]  cnt_t;
  typedef logic [TMR_BYTE_W-1:0] byte_t;

  typedef enum logic {
    OFS_UPPER = 1'b0,
    OFS_LOWER = 1'b1
  } cnt_ofs_e;

  typedef struct packed {
    cnt_t value;
    logic rolled;
  } cnt_step_t;

  // One counting step: advance on tick, flag rollover from all ones.
  function automatic cnt_step_t step_count(input cnt_t cur, input logic tick);
    cnt_step_t r;
    r.value  = tick ? cur + 1'b1 : cur;
    r.rolled = tick && (cur == '1);
    return r;
  endfunction

  // Selected byte for a read access.
  function automatic byte_t pick_byte(input cnt_t cur, input logic lower,
                                      input logic held, input byte_t snap);
    if (!lower) return cur[TMR_CNT_W-1:TMR_BYTE_W];
    return held ? snap : cur[TMR_BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned SEL_W       = TMR_SEL_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] src,
  input  logic             ext_clk,
  output logic             ext_rise,
  output logic             tick
);
  localparam int unsigned N_SRC    = 1 << SEL_W;
  localparam int unsigned EXT_CODE = N_SRC - 1;
  localparam int unsigned DIV_W    = EXT_CODE - 1;

  logic [DIV_W-1:0]     div_q;
  logic [SYNC_STAGES:0] sync_q;
  logic [N_SRC-1:0]     tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  for (genvar g = 0; g < N_SRC; g++) begin : g_tap
    if (g == 0) begin : g_bus
      assign tap[g] = 1'b1;
    end else if (g == EXT_CODE) begin : g_ext
      assign tap[g] = ext_rise;
    end else begin : g_div
      assign tap[g] = &div_q[g-1:0];
    end
  end

  assign tick = tap[src];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output cnt_t count,
  output logic wrap
);
  cnt_step_t nxt;

  always_comb nxt = step_count(count, tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wrap  <= 1'b0;
    end else if (clear) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      count <= nxt.value;
      wrap  <= nxt.rolled;
    end
  end
endmodule

// File: rtl/tmr_readout.sv
module tmr_readout
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  rd_upper,
  input  logic  rd_lower,
  input  logic  rd_active,
  input  logic  lower_sel,
  input  cnt_t  count,
  output byte_t rdata,
  output logic  hold,
  output byte_t hold_buf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= 1'b0;
      hold_buf <= '0;
    end else if (clear || rd_lower) begin
      hold <= 1'b0;
    end else if (rd_upper && !hold) begin
      hold     <= 1'b1;
      hold_buf <= count[TMR_BYTE_W-1:0];
    end
  end

  always_comb
    rdata = rd_active ? pick_byte(count, lower_sel, hold, hold_buf) : '0;
endmodule

// File: rtl/coherent_timer.sv
module coherent_timer
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [TMR_SEL_W-1:0]  cfg_src,
  input  logic                  cfg_clr,
  input  logic                  ext_clk,
  input  logic                  bus_en,
  input  logic                  bus_wr,
  input  logic                  bus_addr,
  output logic [TMR_BYTE_W-1:0] bus_rdata,
  output logic [TMR_SEL_W-1:0]  src_sel,
  output logic [TMR_CNT_W-1:0]  count_o,
  output logic                  wrap_o
);
  logic  clr_q;
  logic  tick;
  logic  ext_rise;
  logic  rd_active;
  logic  rd_upper;
  logic  rd_lower;
  logic  hold;
  byte_t hold_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= '0;
      clr_q   <= 1'b0;
    end else if (cfg_we) begin
      src_sel <= cfg_src;
      clr_q   <= cfg_clr;
    end else begin
      clr_q   <= 1'b0;
    end
  end

  assign rd_active = bus_en && !bus_wr;
  assign rd_upper  = rd_active && (cnt_ofs_e'(bus_addr) == OFS_UPPER);
  assign rd_lower  = rd_active && (cnt_ofs_e'(bus_addr) == OFS_LOWER);

  tmr_prescaler #(.SEL_W(TMR_SEL_W), .SYNC_STAGES(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(clr_q), .src(src_sel),
    .ext_clk(ext_clk), .ext_rise(ext_rise), .tick(tick)
  );

  tmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clr_q), .tick(tick),
    .count(count_o), .wrap(wrap_o)
  );

  tmr_readout u_rd (
    .clk(clk), .rst_n(rst_n), .clear(clr_q), .rd_upper(rd_upper),
    .rd_lower(rd_lower), .rd_active(rd_active), .lower_sel(bus_addr),
    .count(count_o), .rdata(bus_rdata), .hold(hold), .hold_buf(hold_buf)
  );
endmodule

// File: rtl/coherent_timer_checks.sv
module coherent_timer_checks
  import tmr_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  clr_q,
  input cnt_t  count_o,
  input logic  wrap_o,
  input logic  rd_upper,
  input logic  rd_lower,
  input logic  hold,
  input byte_t hold_buf
);
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |=> (count_o == $past(count_o)) || (count_o == cnt_t'($past(count_o) + 1'b1)));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> count_o == '0);

  a_r9_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (count_o == '0) && ($past(count_o) == '1));

  a_r9_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o);

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_upper && !hold && !clr_q) |=>
      hold && (hold_buf == $past(count_o[TMR_BYTE_W-1:0])));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !rd_lower && !clr_q) |=> hold && $stable(hold_buf));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lower || clr_q) |=> !hold);
endmodule

bind coherent_timer coherent_timer_checks u_chk (
  .clk(clk), .rst_n(rst_n), .clr_q(clr_q), .count_o(count_o),
  .wrap_o(wrap_o), .rd_upper(rd_upper), .rd_lower(rd_lower),
  .hold(hold), .hold_buf(hold_buf)
);

// File: tb/test_coherent_timer.sv
`timescale 1ns/1ps
module test_coherent_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_src = 3'd0;
  logic       cfg_clr = 1'b0;
  logic       ext_clk = 1'b0;
  logic       bus_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_rdata;
  logic [2:0] src_sel;
  logic [15:0] count_o;
  logic       wrap_o;

  always #10 clk = ~clk;

  coherent_timer i_coherent_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_clr(cfg_clr), .ext_clk(ext_clk), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .src_sel(src_sel),
    .count_o(count_o), .wrap_o(wrap_o)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int wraps_seen = 0;
  bit done = 0;
  string cur_req = "R3";

  // Behavioural reference state
  int m_cnt, m_src, m_clr, m_phase, m_held, m_snap, m_wrap;
  int m_e0, m_e1, m_e2;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  function automatic int exp_rdata();
    if (!bus_en || bus_wr) return 0;
    if (!bus_addr) return (m_cnt >> 8) & 255;
    return m_held ? m_snap : (m_cnt & 255);
  endfunction

  // Reference step at every rising edge, using inputs settled since the falling edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_src = 0; m_clr = 0; m_phase = 0; m_held = 0; m_snap = 0;
      m_wrap = 0; m_e0 = 0; m_e1 = 0; m_e2 = 0;
    end else begin
      int period;
      bit t;
      bit rd_hi, rd_lo;
      cycles++;
      period = 1 << m_src;
      if (m_src == 7) t = (m_e1 == 1) && (m_e2 == 0);
      else            t = (m_phase % period) == (period - 1);
      rd_hi = bus_en && !bus_wr && !bus_addr;
      rd_lo = bus_en && !bus_wr && bus_addr;
      if (m_clr != 0) begin
        m_wrap = 0;
        m_held = 0;
      end else begin
        m_wrap = (t && m_cnt == 65535) ? 1 : 0;
        if (rd_lo) m_held = 0;
        else if (rd_hi && m_held == 0) begin
          m_held = 1;
          m_snap = m_cnt & 255;
        end
      end
      m_cnt   = (m_clr != 0) ? 0 : (t ? ((m_cnt + 1) & 65535) : m_cnt);
      m_phase = (m_clr != 0) ? 0 : ((m_phase + 1) % 64);
      if (cfg_we) begin
        m_src = cfg_src;
        m_clr = cfg_clr;
      end else m_clr = 0;
      m_e2 = m_e1; m_e1 = m_e0; m_e0 = ext_clk;
    end
  end

  // Per-cycle comparison a quarter period before the next rising edge
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(cur_req, "count", count_o, m_cnt);
      chk(cur_req, "wrap", wrap_o, m_wrap);
      chk(cur_req, "rdata", bus_rdata, exp_rdata());
      chk(cur_req, "src", src_sel, m_src);
      if (wrap_o) wraps_seen++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input int src, input bit clr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_src = 3'(src); cfg_clr = clr;
    @(negedge clk);
    cfg_we = 1'b0; cfg_clr = 1'b0;
  endtask

  task automatic bus_read(input bit addr, output int data);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    #3 data = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic bus_write(input bit addr);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = addr;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int d, snap, c0;
    #1;
    // R3: reset state
    chk("R3", "count in reset", count_o, 0);
    chk("R3", "src in reset", src_sel, 0);
    chk("R3", "rdata idle", bus_rdata, 0);
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R3", "src after reset", src_sel, 0);

    // R1: divide by 1 through 64
    cur_req = "R1";
    idle(20);
    for (int k = 1; k < 7; k++) begin
      cfg(k, 1'b0);
      idle(200);
    end

    // R7, R8: restart with divide by 8
    cur_req = "R8";
    cfg(3, 1'b1);
    idle(1);
    chk("R7", "count zero two edges after restart write", count_o, 0);
    idle(7);
    chk("R8", "no tick before full period", count_o, 0);
    idle(1);
    chk("R8", "first tick one full period after clear", count_o, 1);
    idle(30);

    // R5, R6: coherent snapshot across repeated upper reads
    cur_req = "R5";
    cfg(0, 1'b1);
    idle(300);
    bus_read(1'b0, d);
    snap = m_snap;
    chk("R5", "upper byte", d, (count_o >> 8) & 255);
    cur_req = "R6";
    idle(37);
    bus_read(1'b0, d);
    idle(50);
    bus_read(1'b0, d);
    bus_read(1'b1, d);
    chk("R6", "low byte from snapshot after repeated upper reads", d, snap);

    // R4: writes ignored
    cur_req = "R4";
    bus_read(1'b0, d);
    snap = m_snap;
    bus_write(1'b1);
    bus_write(1'b0);
    idle(5);
    bus_read(1'b1, d);
    chk("R4", "snapshot kept across writes", d, snap);

    // R10: live low read, restart releases snapshot
    cur_req = "R10";
    cfg(1, 1'b0);
    idle(4);
    bus_read(1'b1, d);
    chk("R10", "live low byte without snapshot", d >= 0 ? 1 : 0, 1);
    bus_read(1'b0, d);
    cfg(1, 1'b1);
    idle(3);
    @(negedge clk);
    bus_en = 1'b1; bus_addr = 1'b1;
    #3 chk("R10", "low read after restart is live", bus_rdata, count_o & 255);
    @(negedge clk);
    bus_en = 1'b0; bus_addr = 1'b0;

    // R2: external clock edges
    cur_req = "R2";
    cfg(7, 1'b1);
    idle(2);
    c0 = count_o;
    for (int e = 0; e < 20; e++) begin
      @(negedge clk); ext_clk = 1'b1;
      idle(3);
      @(negedge clk); ext_clk = 1'b0;
      idle(3);
    end
    idle(4);
    chk("R2", "one count per external rising edge", count_o - c0, 20);

    // R9: full rollover at divide by 1
    cur_req = "R9";
    wraps_seen = 0;
    cfg(0, 1'b1);
    idle(65536 + 10);
    chk("R9", "exactly one wrap pulse", wraps_seen, 1);
    chk("R9", "count after rollover", count_o, m_cnt);

    finish_run();
  end
endmodule